// File: doc/BRIEF.md
# Eight-bit ALU with flag register

This block is the data path of a small eight-bit processor core. It combines two byte operands with one of the listed operations in a single combinational pass. It returns the byte result and a write-back strobe that tells the register file whether to keep the result. It holds a six-bit flag register that commits at every clock edge. Each operation owns a fixed subset of the flags, and every flag outside that subset keeps its value.

Flags come from a 16-bit intermediate value, formed from the zero-extended operands. A carry out of an addition and the borrow wrap of a subtraction both land in the high byte. The carry and overflow flags are then both raised from that high byte. The same register also holds the interrupt-enable bit and a skip bit, which the core's sequencer uses. The next flag value is also exposed, so that a conditional-branch unit can look ahead without waiting for the edge.

Top module: `alu8_flags`

## Requirements
- R1: After reset the flag register reads 6'h10: only the interrupt-enable bit (bit 4) is set.
- R2: When an operation updates them, zero (bit 0) is set exactly when the low byte of the 16-bit intermediate is 0, and sign (bit 3) copies bit 7 of the intermediate.
- R3: ADD (code 4), SUB (5), CMP (6), INC (7) and DEC (8) build the intermediate from zero-extended operands. Carry (bit 1) and overflow (bit 2) are both set when any bit above bit 7 is 1, which covers a carry out and a borrow, and are both cleared otherwise. Zero and sign are updated too.
- R4: AND (1), OR (2) and XOR (3) write their result back and update only zero and sign.
- R5: CMP sets the flags exactly as SUB does but holds write-back low. Every data operation except CMP drives write-back high.
- R6: SHL (9) and SHR (10) shift operand A by amt_i and update zero, carry and sign. SHL sets carry when a 1 bit is shifted past bit 7. SHR always clears carry. Overflow is unchanged.
- R7: ROL (11) and ROR (12) rotate operand A by amt_i and update zero, carry and sign. Carry is set when any bit that wrapped around is 1. An amount of 0 returns the operand unchanged with carry cleared.
- R8: BIT (13) sets zero when bit amt_i of operand A is 0 and clears it when that bit is 1. It changes no other flag and holds write-back low.
- R9: SETC (14), CLRC (15), SETO (16), CLRO (17), SETI (18) and CLRI (19) each set or clear only carry, overflow or interrupt-enable respectively. Write-back is low.
- R10: NOP (0) leaves every flag unchanged and holds write-back low.
- R11: Op codes 20 to 31 behave as NOP.
- R12: The skip bit (bit 5) is changed by no operation and stays 0 after reset.
- R13: flags_nxt_o shows, within the same cycle, the value that flags_o takes at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| opa_i | input | 8 | Operand A (destination value) |
| opb_i | input | 8 | Operand B (source register or immediate) |
| amt_i | input | 3 | Shift, rotate or bit-index amount |
| res_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Result should be written back |
| flags_o | output | 6 | Registered flags |
| flags_nxt_o | output | 6 | Flag value committed at the next edge |

## Verification
Each cycle does two things at once. The previous operation's flag value commits, and the current operation merges its own flags into that committed value while passing all the other bits through. Back-to-back operations with disjoint update subsets provoke the overlap. Examples are a carry set followed by a logic operation, or a bit test after an arithmetic overflow. After each edge the bench compares all six bits of the register against a running model, and the look-ahead value is judged before the edge.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int ALU_DW = 8;
    localparam int FLAG_W = 6;

    // flag bit positions (decoded by the branch unit)
    localparam int FZ = 0;
    localparam int FC = 1;
    localparam int FO = 2;
    localparam int FS = 3;
    localparam int FI = 4;
    localparam int FK = 5;

    typedef enum logic [4:0] {
        OP_NOP  = 5'd0,
        OP_AND  = 5'd1,
        OP_OR   = 5'd2,
        OP_XOR  = 5'd3,
        OP_ADD  = 5'd4,
        OP_SUB  = 5'd5,
        OP_CMP  = 5'd6,
        OP_INC  = 5'd7,
        OP_DEC  = 5'd8,
        OP_SHL  = 5'd9,
        OP_SHR  = 5'd10,
        OP_ROL  = 5'd11,
        OP_ROR  = 5'd12,
        OP_BIT  = 5'd13,
        OP_SETC = 5'd14,
        OP_CLRC = 5'd15,
        OP_SETO = 5'd16,
        OP_CLRO = 5'd17,
        OP_SETI = 5'd18,
        OP_CLRI = 5'd19
    } alu_op_e;

    localparam int OP_W = $bits(alu_op_e);

    typedef struct packed {
        logic              wr;
        logic [FLAG_W-1:0] upd;
        logic [FLAG_W-1:0] set;
        logic [FLAG_W-1:0] clr;
    } op_ctrl_t;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } flag_state_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
#(
    parameter int FW = FLAG_W
) (
    input  alu_op_e          op,
    output logic             wr,
    output logic [FW-1:0]    upd,
    output logic [FW-1:0]    set,
    output logic [FW-1:0]    clr
);

    localparam logic [FW-1:0] M_Z = FW'(1) << FZ;
    localparam logic [FW-1:0] M_C = FW'(1) << FC;
    localparam logic [FW-1:0] M_O = FW'(1) << FO;
    localparam logic [FW-1:0] M_S = FW'(1) << FS;
    localparam logic [FW-1:0] M_I = FW'(1) << FI;

    localparam logic [FW-1:0] M_LOGIC = M_Z | M_S;
    localparam logic [FW-1:0] M_ARITH = M_Z | M_C | M_O | M_S;
    localparam logic [FW-1:0] M_SHIFT = M_Z | M_C | M_S;

    op_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d     = '0;
        case (op)
            OP_AND, OP_OR, OP_XOR: begin
                ctrl_d.wr  = 1'b1;
                ctrl_d.upd = M_LOGIC;
            end
            OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
                ctrl_d.wr  = 1'b1;
                ctrl_d.upd = M_ARITH;
            end
            OP_CMP: begin
                ctrl_d.upd = M_ARITH;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                ctrl_d.wr  = 1'b1;
                ctrl_d.upd = M_SHIFT;
            end
            OP_BIT:  ctrl_d.upd = M_Z;
            OP_SETC: ctrl_d.set = M_C;
            OP_CLRC: ctrl_d.clr = M_C;
            OP_SETO: ctrl_d.set = M_O;
            OP_CLRO: ctrl_d.clr = M_O;
            OP_SETI: ctrl_d.set = M_I;
            OP_CLRI: ctrl_d.clr = M_I;
            default: ctrl_d = '0;
        endcase
    end

    assign wr  = ctrl_d.wr;
    assign upd = ctrl_d.upd;
    assign set = ctrl_d.set;
    assign clr = ctrl_d.clr;

endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int DW = ALU_DW,
    parameter int WW = 2 * DW
) (
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    output logic [WW-1:0]    wide,
    output logic             hit
);

    logic [WW-1:0] ea;
    logic [WW-1:0] eb;

    assign ea = {{(WW-DW){1'b0}}, a};
    assign eb = {{(WW-DW){1'b0}}, b};

    always_comb begin
        hit  = 1'b1;
        case (op)
            OP_AND:         wide = ea & eb;
            OP_OR:          wide = ea | eb;
            OP_XOR:         wide = ea ^ eb;
            OP_ADD:         wide = ea + eb;
            OP_SUB, OP_CMP: wide = ea - eb;
            OP_INC:         wide = ea + WW'(1);
            OP_DEC:         wide = ea - WW'(1);
            default: begin
                wide = '0;
                hit  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int DW = ALU_DW,
    parameter int AW = $clog2(DW),
    parameter int WW = 2 * DW
) (
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [AW-1:0]    amt,
    output logic [WW-1:0]    wide,
    output logic             hit
);

    logic [WW-1:0] ext;
    logic [WW-1:0] dbl;
    logic [WW-1:0] shl_w;
    logic [WW-1:0] shr_w;
    logic [WW-1:0] rol_w;
    logic [WW-1:0] ror_w;
    logic [DW-1:0] low_mask;
    logic [DW-1:0] sel_oh;

    assign ext      = {{(WW-DW){1'b0}}, a};
    assign dbl      = {a, a};
    assign shl_w    = ext << amt;
    assign shr_w    = ext >> amt;
    assign rol_w    = dbl << amt;
    assign ror_w    = dbl >> amt;
    assign low_mask = (DW'(1) << amt) - DW'(1);

    // one-hot bit selector for the bit test
    for (genvar i = 0; i < DW; i++) begin : g_sel
        assign sel_oh[i] = (amt == AW'(i));
    end

    always_comb begin
        hit = 1'b1;
        case (op)
            OP_SHL: wide = shl_w;
            OP_SHR: wide = shr_w;
            // high byte carries the bits that wrapped around
            OP_ROL: wide = {shl_w[WW-1:DW], rol_w[WW-1:DW]};
            OP_ROR: wide = {a & low_mask, ror_w[DW-1:0]};
            OP_BIT: wide = {{(WW-DW){1'b0}}, a & sel_oh};
            default: begin
                wide = '0;
                hit  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
    import alu8_pkg::*;
#(
    parameter int FW = FLAG_W,
    parameter int DW = ALU_DW,
    parameter int WW = 2 * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WW-1:0]    wide,
    input  logic [FW-1:0]    upd,
    input  logic [FW-1:0]    set,
    input  logic [FW-1:0]    clr,
    output logic [FW-1:0]    flags_q,
    output logic [FW-1:0]    flags_d
);

    localparam logic [FW-1:0] RST_FLAGS = FW'(1) << FI;

    flag_state_t st_d;
    flag_state_t st_q;
    logic        z_w;
    logic        hi_w;
    logic        s_w;

    assign z_w  = (wide[DW-1:0] == '0);
    assign hi_w = |wide[WW-1:DW];
    assign s_w  = wide[DW-1];

    always_comb begin
        st_d = st_q;
        if (upd[FZ]) st_d.flags[FZ] = z_w;
        if (upd[FC]) st_d.flags[FC] = hi_w;
        if (upd[FO]) st_d.flags[FO] = hi_w;
        if (upd[FS]) st_d.flags[FS] = s_w;
        st_d.flags = (st_d.flags | set) & ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flags: RST_FLAGS};
        else        st_q <= st_d;
    end

    assign flags_q = st_q.flags;
    assign flags_d = st_d.flags;

    AST_SKIP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(flags_q[FK])); // R12

    AST_CARRY_OVF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (upd[FC] && upd[FO]) |=> (flags_q[FC] == flags_q[FO])); // R3

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int DW = ALU_DW,
    parameter int FW = FLAG_W,
    parameter int AW = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_i,
    input  logic [DW-1:0]    opa_i,
    input  logic [DW-1:0]    opb_i,
    input  logic [AW-1:0]    amt_i,
    output logic [DW-1:0]    res_o,
    output logic             wr_en_o,
    output logic [FW-1:0]    flags_o,
    output logic [FW-1:0]    flags_nxt_o
);

    localparam int WW = 2 * DW;

    alu_op_e       op_e;
    logic [WW-1:0] ar_wide;
    logic [WW-1:0] sh_wide;
    logic          ar_hit;
    logic          sh_hit;
    logic [WW-1:0] wide;
    logic [FW-1:0] upd;
    logic [FW-1:0] set;
    logic [FW-1:0] clr;

    assign op_e = alu_op_e'(op_i);

    alu8_decode #(.FW(FW)) u_dec (
        .op  (op_e),
        .wr  (wr_en_o),
        .upd (upd),
        .set (set),
        .clr (clr)
    );

    alu8_arith #(.DW(DW), .WW(WW)) u_arith (
        .op   (op_e),
        .a    (opa_i),
        .b    (opb_i),
        .wide (ar_wide),
        .hit  (ar_hit)
    );

    alu8_shift #(.DW(DW), .AW(AW), .WW(WW)) u_shift (
        .op   (op_e),
        .a    (opa_i),
        .amt  (amt_i),
        .wide (sh_wide),
        .hit  (sh_hit)
    );

    always_comb begin
        if (ar_hit)      wide = ar_wide;
        else if (sh_hit) wide = sh_wide;
        else             wide = '0;
    end

    alu8_flagreg #(.FW(FW), .DW(DW), .WW(WW)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wide    (wide),
        .upd     (upd),
        .set     (set),
        .clr     (clr),
        .flags_q (flags_o),
        .flags_d (flags_nxt_o)
    );

    assign res_o = wide[DW-1:0];

    AST_LOGIC_KEEPS_CO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_AND || op_e == OP_OR || op_e == OP_XOR)
        |=> $stable(flags_o[FO:FC])); // R4

    AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_CMP) |-> !wr_en_o); // R5

    AST_ROT_ZERO_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_e == OP_ROL || op_e == OP_ROR) && amt_i == '0)
        |-> (res_o == opa_i && !flags_nxt_o[FC])); // R7

    AST_BIT_ONLY_Z: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_BIT) |=> $stable(flags_o[FW-1:1])); // R8

    AST_SETC_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_SETC) |=> flags_o[FC]); // R9

    AST_NXT_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flags_o == $past(flags_nxt_o))); // R13

endmodule

// File: tb/sim_alu8_flags.sv
module sim_alu8_flags;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_i = 5'd0;
    logic [7:0] opa_i = 8'd0;
    logic [7:0] opb_i = 8'd0;
    logic [2:0] amt_i = 3'd0;
    logic [7:0] res_o;
    logic       wr_en_o;
    logic [5:0] flags_o;
    logic [5:0] flags_nxt_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] res;
        logic       wr;
        logic [5:0] flg;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    logic [5:0] mflg;
    bit         mon_on = 1'b0;

    always #4 clk = ~clk;

    alu8_flags u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .amt_i      (amt_i),
        .res_o      (res_o),
        .wr_en_o    (wr_en_o),
        .flags_o    (flags_o),
        .flags_nxt_o(flags_nxt_o)
    );

    // reference model written from the requirement list
    function automatic void ref_op(input logic [4:0] op, input logic [7:0] a,
                                   input logic [7:0] b, input logic [2:0] n,
                                   inout logic [5:0] f, output logic [7:0] r,
                                   output logic w);
        logic [7:0] v = 8'd0;
        logic c = 1'b0;
        bit zs = 0, cov = 0, conly = 0;
        w = 1'b0;
        case (op)
            5'd1: begin v = a & b; w = 1; zs = 1; end
            5'd2: begin v = a | b; w = 1; zs = 1; end
            5'd3: begin v = a ^ b; w = 1; zs = 1; end
            5'd4: begin v = a + b; c = (int'(a) + int'(b)) > 255; w = 1; zs = 1; cov = 1; end
            5'd5: begin v = a - b; c = a < b; w = 1; zs = 1; cov = 1; end
            5'd6: begin v = a - b; c = a < b; zs = 1; cov = 1; end
            5'd7: begin v = a + 8'd1; c = (a == 8'hFF); w = 1; zs = 1; cov = 1; end
            5'd8: begin v = a - 8'd1; c = (a == 8'h00); w = 1; zs = 1; cov = 1; end
            5'd9: begin v = a << n; c = (n != 0) && ((int'(a) >> (8 - int'(n))) != 0);
                        w = 1; zs = 1; conly = 1; end
            5'd10: begin v = a >> n; c = 1'b0; w = 1; zs = 1; conly = 1; end
            5'd11: begin
                v = (n == 0) ? a : 8'((int'(a) << n) | (int'(a) >> (8 - int'(n))));
                c = (n != 0) && ((int'(a) >> (8 - int'(n))) != 0);
                w = 1; zs = 1; conly = 1;
            end
            5'd12: begin
                v = (n == 0) ? a : 8'((int'(a) >> n) | (int'(a) << (8 - int'(n))));
                c = (int'(a) & ((1 << n) - 1)) != 0;
                w = 1; zs = 1; conly = 1;
            end
            5'd13: f[0] = ~a[n];
            5'd14: f[1] = 1'b1;
            5'd15: f[1] = 1'b0;
            5'd16: f[2] = 1'b1;
            5'd17: f[2] = 1'b0;
            5'd18: f[4] = 1'b1;
            5'd19: f[4] = 1'b0;
            default: ;
        endcase
        if (zs) begin f[0] = (v == 8'd0); f[3] = v[7]; end
        if (cov) begin f[1] = c; f[2] = c; end
        if (conly) f[1] = c;
        r = v;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%02h expected=0x%02h", tag, what, act, exp);
        end
    endtask

    // driver: applies one operation and queues its expected outcome
    task automatic drive(input logic [4:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [2:0] n, input string tag);
        exp_t e;
        logic [7:0] r;
        logic w;
        @(negedge clk);
        op_i = op; opa_i = a; opb_i = b; amt_i = n;
        ref_op(op, a, b, n, mflg, r, w);
        #1;
        check("R13", {tag, " look-ahead flags"}, {2'b00, flags_nxt_o}, {2'b00, mflg});
        e.res = r; e.wr = w; e.flg = mflg; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compares after the edge that commits the queued operation
    initial begin
        exp_t e;
        wait (mon_on);
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                check(e.tag, "flags", {2'b00, flags_o}, {2'b00, e.flg});
                check(e.tag, "write-back", {7'd0, wr_en_o}, {7'd0, e.wr});
                if (e.wr) check(e.tag, "result", res_o, e.res);
            end
        end
    end

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "reset flags", {2'b00, flags_o}, 8'h10);
        check("R12", "reset skip bit", {7'd0, flags_o[5]}, 8'h00);
        mflg = 6'h10;
        mon_on = 1'b1;

        drive(5'd14, 8'h00, 8'h00, 3'd0, "R9 SETC");
        drive(5'd1,  8'hF0, 8'h0F, 3'd0, "R4 AND zero, carry kept");
        drive(5'd2,  8'h80, 8'h01, 3'd0, "R2 OR sign");
        drive(5'd3,  8'hAA, 8'hAA, 3'd0, "R4 XOR");
        drive(5'd4,  8'hFF, 8'h01, 3'd0, "R3 ADD wrap");
        drive(5'd4,  8'h10, 8'h20, 3'd0, "R3 ADD plain");
        drive(5'd5,  8'h05, 8'h06, 3'd0, "R3 SUB borrow");
        drive(5'd6,  8'h40, 8'h40, 3'd0, "R5 CMP equal");
        drive(5'd6,  8'h10, 8'h20, 3'd0, "R5 CMP borrow");
        drive(5'd7,  8'hFF, 8'h00, 3'd0, "R3 INC wrap");
        drive(5'd8,  8'h00, 8'h00, 3'd0, "R3 DEC wrap");
        drive(5'd8,  8'h81, 8'h00, 3'd0, "R3 DEC sign");
        drive(5'd16, 8'h00, 8'h00, 3'd0, "R9 SETO");
        drive(5'd9,  8'h81, 8'h00, 3'd1, "R6 SHL carry, overflow kept");
        drive(5'd9,  8'h21, 8'h00, 3'd0, "R6 SHL by 0");
        drive(5'd10, 8'h81, 8'h00, 3'd1, "R6 SHR");
        drive(5'd11, 8'h81, 8'h00, 3'd1, "R7 ROL wrap");
        drive(5'd12, 8'h01, 8'h00, 3'd1, "R7 ROR wrap");
        drive(5'd11, 8'hA5, 8'h00, 3'd0, "R7 ROL by 0");
        drive(5'd12, 8'h5A, 8'h00, 3'd0, "R7 ROR by 0");
        drive(5'd12, 8'hF0, 8'h00, 3'd4, "R7 ROR no carry");
        drive(5'd13, 8'h08, 8'h00, 3'd3, "R8 BIT set");
        drive(5'd13, 8'h08, 8'h00, 3'd2, "R8 BIT clear");
        drive(5'd17, 8'h00, 8'h00, 3'd0, "R9 CLRO");
        drive(5'd15, 8'h00, 8'h00, 3'd0, "R9 CLRC");
        drive(5'd19, 8'h00, 8'h00, 3'd0, "R9 CLRI");
        drive(5'd0,  8'h12, 8'h34, 3'd5, "R10 NOP");
        drive(5'd18, 8'h00, 8'h00, 3'd0, "R9 SETI");
        drive(5'd23, 8'hFF, 8'hFF, 3'd7, "R11 unused code");
        drive(5'd31, 8'h00, 8'h00, 3'd0, "R11 top code");
        for (int i = 0; i < 12; i++) begin
            drive(5'(4 + (i % 9)), 8'(i * 37 + 11), 8'(i * 91 + 200), 3'(i), "R12 sweep");
        end
        repeat (3) @(posedge clk);
        #3;
        check("R12", "skip bit held", {7'd0, flags_o[5]}, 8'h00);
        finish_run();
    end

endmodule